// File: doc/BRIEF.md
# Status-Coded I2C Master Byte Engine

This block is an I2C master that software steps through one bus action at a time. Software writes a control byte to ask for a START, a byte transfer or a STOP. The engine performs that action on the open-drain SCL and SDA lines, with one bus phase per pulse of an external bit-rate tick. When a START or byte step is done, the engine sets a flag bit, publishes an 8-bit status code and holds SCL low. It does nothing more until software clears the flag. The status code tells the driver which step finished and whether the far side acknowledged.

The register window has four offsets:
- 0 is control.
- 1 is the data byte. It is sent MSB first, and after a receive it holds the byte that came in.
- 2 reads the status code. A write to offset 2 loads the bit-rate setting that the external divider uses.
- 3 is a write-only soft reset.

The engine drives a line low by raising `scl_lo` or `sda_lo`. It reads the wired-AND level of SDA on `sda_in`. The engine covers master transmit and master receive with 7-bit addressing. The first byte after a START is the address, and its bit 0 selects the direction: 1 means read.

Top module: `i2c_step_master`

## Requirements
- R1: After reset, status reads 0xF8, control reads 0x00, both lines are released, `irq` is low and `baud_cfg` is 0x44.
- R2: The control bits are: bit 2 ACK enable, bit 3 step flag, bit 4 STOP request, bit 5 START request, bit 6 enable, bit 7 interrupt enable. With enable set, a START request from idle produces a START condition, status 0x08, the flag set and SCL held low.
- R3: While the flag is set, SCL stays low, SDA does not change and the status does not change.
- R4: The address byte is shifted MSB first, and its bit 0 is the direction. The resulting status is one of:
  - 0x18: write, acknowledged
  - 0x20: write, not acknowledged
  - 0x40: read, acknowledged
  - 0x48: read, not acknowledged
- R5: A data byte placed at offset 1 is sent MSB first when the flag is cleared. The status is 0x28 if it is acknowledged and 0x30 if it is not.
- R6: In receive, the ACK enable bit makes the master drive ACK, giving status 0x50, or leave SDA released (NAK), giving status 0x58. Offset 1 then reads the received byte.
- R7: A START request while a transfer is held produces a repeated START with status 0x10.
- R8: A STOP request never sets the flag. On completion the status returns to 0xF8, both lines are released, and the START and STOP bits read back as 0.
- R9: With the default polarity, the flag is cleared by a control write with bit 3 = 0. A write with bit 3 = 1 leaves the flag set and launches nothing. A parameter swaps this to write-1-to-clear.
- R10: `irq` is high exactly when the flag and the interrupt-enable bit are both set.
- R11: A write to offset 2 sets `baud_cfg`. A write to offset 3, even in mid-byte, returns the engine to idle with status 0xF8, control 0x00, `baud_cfg` 0x44 and both lines released.
- R12: If the engine completes a step in the same cycle that a control write clears the flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Bit-rate phase enable from external divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| baud_cfg | output | 8 | Bit-rate setting for the external divider |
| scl_lo | output | 1 | Pull SCL low when 1 |
| sda_lo | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA bus level |

## Verification
Two things can happen in the same clock: the engine finishing a byte, which sets the flag, and a software control write that clears it. To provoke this, the bench stops the free-running tick and hands out the 36 phase ticks of a byte one at a time. It checks that the flag is still clear before the last tick. It then issues the final tick in the same cycle as a flag-clearing control write. The result is judged at the ports: the flag must read back set, and the status must show the acknowledged data code 0x28.

// File: rtl/i2c_step_master.sv
`timescale 1ns/1ps
module i2c_step_master #(
  parameter bit         CLR_BY_ONE = 1'b0,
  parameter logic [7:0] BAUD_INIT  = 8'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic [7:0] baud_cfg,
  output logic       scl_lo,
  output logic       sda_lo,
  input  logic       sda_in
);

  localparam logic [7:0] C_START = 8'h08, C_RSTART = 8'h10;
  localparam logic [7:0] C_AW_ACK = 8'h18, C_AW_NAK = 8'h20;
  localparam logic [7:0] C_DW_ACK = 8'h28, C_DW_NAK = 8'h30;
  localparam logic [7:0] C_AR_ACK = 8'h40, C_AR_NAK = 8'h48;
  localparam logic [7:0] C_DR_ACK = 8'h50, C_DR_NAK = 8'h58;
  localparam logic [7:0] C_IDLE = 8'hF8;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BYTE, S_HOLD, S_STOP} st_t;

  st_t        st;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic       ack_en, iflg, stop_rq, start_rq, en, ien;
  logic       addr_next, rd_mode, rep, got_ack;
  logic [7:0] data_q, status_q, baud_q;
  logic [7:0] done_code;

  wire ctrl_wr  = wr_en && wr_addr == 2'd0;
  wire srst     = wr_en && wr_addr == 2'd3;
  wire iflg_clr = ctrl_wr && (CLR_BY_ONE ? wr_data[3] : !wr_data[3]);
  wire tx_dir   = addr_next || !rd_mode;

  assign irq      = iflg && ien;
  assign baud_cfg = baud_q;

  always_comb begin
    if (addr_next)
      done_code = data_q[0] ? (got_ack ? C_AR_ACK : C_AR_NAK) : (got_ack ? C_AW_ACK : C_AW_NAK);
    else if (rd_mode)
      done_code = ack_en ? C_DR_ACK : C_DR_NAK;
    else
      done_code = got_ack ? C_DW_ACK : C_DW_NAK;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {ien, en, start_rq, stop_rq, iflg, ack_en, 2'b00};
      2'd1:    rd_data = data_q;
      2'd2:    rd_data = status_q;
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st <= S_IDLE; ph <= '0; bitn <= '0;
      ack_en <= 1'b0; iflg <= 1'b0; stop_rq <= 1'b0; start_rq <= 1'b0; en <= 1'b0; ien <= 1'b0;
      addr_next <= 1'b0; rd_mode <= 1'b0; rep <= 1'b0; got_ack <= 1'b0;
      data_q <= '0; status_q <= C_IDLE; baud_q <= BAUD_INIT;
      scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ack_en <= wr_data[2]; stop_rq <= wr_data[4]; start_rq <= wr_data[5];
        en <= wr_data[6]; ien <= wr_data[7];
        if (iflg_clr) iflg <= 1'b0;
      end
      if (wr_en && wr_addr == 2'd1) data_q <= wr_data;
      if (wr_en && wr_addr == 2'd2) baud_q <= wr_data;
      case (st)
        S_IDLE:
          if (stop_rq) stop_rq <= 1'b0;
          else if (en && start_rq) begin st <= S_START; ph <= '0; rep <= 1'b0; end
        S_HOLD:
          if (en && !iflg) begin
            ph <= '0; bitn <= '0;
            if (start_rq) begin st <= S_START; rep <= 1'b1; end
            else if (stop_rq) st <= S_STOP;
            else st <= S_BYTE;
          end
        S_START:
          if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b1;
              default: begin
                scl_lo <= 1'b1; st <= S_HOLD; iflg <= 1'b1; start_rq <= 1'b0;
                addr_next <= 1'b1; rd_mode <= 1'b0;
                status_q <= rep ? C_RSTART : C_START;
              end
            endcase
          end
        S_BYTE:
          if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: begin
                scl_lo <= 1'b1;
                if (bitn < 4'd8) sda_lo <= tx_dir && !data_q[7];
                else             sda_lo <= !tx_dir && ack_en;
              end
              2'd1: scl_lo <= 1'b0;
              2'd2:
                if (bitn < 4'd8) data_q <= {data_q[6:0], sda_in};
                else             got_ack <= !sda_in;
              default: begin
                scl_lo <= 1'b1;
                if (bitn == 4'd8) begin
                  st <= S_HOLD; iflg <= 1'b1; status_q <= done_code;
                  if (addr_next) rd_mode <= data_q[0];
                  addr_next <= 1'b0;
                end else bitn <= bitn + 4'd1;
              end
            endcase
          end
        S_STOP:
          if (tick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: begin scl_lo <= 1'b1; sda_lo <= 1'b1; end
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b0;
              default: begin st <= S_IDLE; status_q <= C_IDLE; stop_rq <= 1'b0; end
            endcase
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> status_q == C_IDLE);
  p_flag_from_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflg) |-> st == S_HOLD);
  p_held_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && iflg && !srst) |=> scl_lo && $stable(sda_lo) && $stable(status_q));
  p_sda_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && $past(st) == S_BYTE && sda_lo != $past(sda_lo)) |-> scl_lo && $past(scl_lo));
  p_stop_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && !iflg) |=> !iflg);
  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !scl_lo && !sda_lo);

endmodule

// File: tb/i2c_step_master_test.sv
`timescale 1ns/1ps
module i2c_step_master_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, auto_tick = 1'b1, man_tick = 1'b0, auto_pulse = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0, tdiv = '0;
  logic [7:0] wr_data = '0, rd_data, baud_cfg;
  logic irq, scl_lo, sda_lo;
  wire tick = auto_tick ? auto_pulse : man_tick;

  localparam logic [6:0] SLV = 7'h50;
  int sbit = 0, scl_rises = 0, checks = 0, errors = 0;
  logic [7:0] sh = '0, s_tx = '0, last_rx = '0;
  logic first = 0, s_addr = 0, s_rd = 0, s_lo = 0, m_ack = 0, s_nak = 0;
  wire scl_w = !scl_lo;
  wire sda_w = !(sda_lo || s_lo);

  i2c_step_master uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .baud_cfg(baud_cfg),
    .scl_lo(scl_lo), .sda_lo(sda_lo), .sda_in(sda_w));

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    auto_pulse <= (tdiv == 2'd3);
  end

  always @(negedge sda_w) if (rst_n && scl_w) begin sbit = 0; first = 1; s_addr = 0; s_rd = 0; s_lo = 0; end
  always @(posedge sda_w) if (rst_n && scl_w) begin s_addr = 0; s_rd = 0; first = 0; end
  always @(posedge scl_w) if (rst_n) begin
    scl_rises++;
    if (sbit < 8) sh = {sh[6:0], sda_w}; else m_ack = !sda_w;
    sbit++;
  end
  always @(negedge scl_w) if (rst_n) begin
    if (sbit == 8) begin
      if (first) begin
        first = 0; s_addr = (sh[7:1] == SLV); s_rd = s_addr && sh[0]; s_lo = s_addr;
        if (s_rd) s_tx = 8'hC3;
      end else if (s_addr && !s_rd) begin last_rx = sh; s_lo = !s_nak; end
      else begin s_lo = 0; if (s_rd) s_tx = s_tx + 8'd1; end
    end else if (sbit >= 9) begin
      sbit = 0;
      if (s_rd && m_ack) s_lo = !s_tx[7]; else begin s_lo = 0; s_rd = 0; end
    end else if (s_rd && sbit >= 1) s_lo = !s_tx[7-sbit];
    else s_lo = 0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0h expected %0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #0.1; v = rd_data;
  endtask

  task automatic wait_flag(input string tag);
    logic [7:0] v; int n;
    n = 0; rd(2'd0, v);
    while (!v[3] && n < 4000) begin @(negedge clk); rd(2'd0, v); n++; end
    if (!v[3]) chk(1'b0, tag, v, 8'h08);
  endtask

  task automatic expect_status(input logic [7:0] e, input string tag);
    logic [7:0] v;
    wait_flag(tag); rd(2'd2, v); chk(v == e, tag, v, e);
  endtask

  task automatic do_stop(input string tag);
    logic [7:0] v; int n;
    wr(2'd0, 8'hD0);
    n = 0; rd(2'd2, v);
    while (v != 8'hF8 && n < 4000) begin @(negedge clk); rd(2'd2, v); n++; end
    chk(v == 8'hF8, {tag, " R8 idle code"}, v, 8'hF8);
    rd(2'd0, v);
    chk((v & 8'h38) == 0, {tag, " R8 no flag, requests cleared"}, v & 8'h38, 0);
    chk(!scl_lo && !sda_lo && sda_w, {tag, " R8 lines released"}, {scl_lo, sda_lo}, 0);
  endtask

  task automatic send(input logic [7:0] b, input logic [7:0] e, input string tag);
    wr(2'd1, b); wr(2'd0, 8'hC0); expect_status(e, tag);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary; $finish;
  end

  initial begin
    logic [7:0] v;
    int rises0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, v); chk(v == 8'hF8, "R1 status", v, 8'hF8);
    rd(2'd0, v); chk(v == 8'h00, "R1 control", v, 0);
    chk(!scl_lo && !sda_lo && !irq, "R1 lines/irq", {scl_lo, sda_lo, irq}, 0);
    chk(baud_cfg == 8'h44, "R1 baud", baud_cfg, 8'h44);

    // R2 and R10: START without interrupt enable, then enable irq without clearing (R9)
    wr(2'd0, 8'h60); expect_status(8'h08, "R2 start code");
    chk(scl_lo, "R2 SCL held", scl_lo, 1);
    chk(!irq, "R10 irq masked", irq, 0);
    wr(2'd0, 8'hC8);
    chk(irq, "R10 irq raised", irq, 1);
    rises0 = scl_rises;
    repeat (80) @(negedge clk);
    rd(2'd0, v); chk(v[3], "R9 bit3=1 keeps flag", v, 8'h08);
    rd(2'd2, v); chk(v == 8'h08, "R3 status held", v, 8'h08);
    chk(scl_rises == rises0 && scl_lo, "R3 no clocking", scl_rises - rises0, 0);
    send({SLV, 1'b0}, 8'h18, "R9 clear by 0 launches");
    do_stop("stop1");

    // R4: exhaustive write-address sweep
    for (int a = 0; a < 128; a++) begin
      wr(2'd0, 8'hE0); expect_status(8'h08, "R2 sweep start");
      send({a[6:0], 1'b0}, (a == SLV) ? 8'h18 : 8'h20, "R4 write address");
      do_stop("R4 sweep");
    end
    // R4: read addresses around the slave
    for (int a = SLV - 2; a <= SLV + 2; a++) begin
      wr(2'd0, 8'hE0); expect_status(8'h08, "R2 start");
      send({a[6:0], 1'b1}, (a == SLV) ? 8'h40 : 8'h48, "R4 read address");
      if (a == SLV) begin
        wr(2'd0, 8'hC0); expect_status(8'h58, "R6 nak receive");
        rd(2'd1, v); chk(v == 8'hC3, "R6 received byte", v, 8'hC3);
      end
      do_stop("R4 read sweep");
    end

    // R5: data bytes MSB first, then a refused byte
    wr(2'd0, 8'hE0); expect_status(8'h08, "R2 start");
    send({SLV, 1'b0}, 8'h18, "R4 address");
    for (int d = 0; d < 256; d += 17) begin
      send(d[7:0], 8'h28, "R5 data ack");
      chk(last_rx == d[7:0], "R5 byte seen on bus", last_rx, d);
    end
    s_nak = 1'b1;
    send(8'h3C, 8'h30, "R5 data nak");
    s_nak = 1'b0;
    do_stop("R5");

    // R6 and R7: pointer write, repeated start, acked and nacked receive
    wr(2'd0, 8'hE0); expect_status(8'h08, "R2 start");
    send({SLV, 1'b0}, 8'h18, "R4 address");
    send(8'h00, 8'h28, "R5 pointer");
    wr(2'd0, 8'hE0); expect_status(8'h10, "R7 repeated start");
    send({SLV, 1'b1}, 8'h40, "R4 read address");
    for (int k = 0; k < 3; k++) begin
      wr(2'd0, 8'hC4); expect_status(8'h50, "R6 ack receive");
      rd(2'd1, v); chk(v == 8'hC3 + k, "R6 data", v, 8'hC3 + k);
      @(negedge clk); chk(m_ack, "R6 ACK driven", m_ack, 1);
    end
    wr(2'd0, 8'hC0); expect_status(8'h58, "R6 final nak");
    rd(2'd1, v); chk(v == 8'hC6, "R6 last data", v, 8'hC6);
    chk(!m_ack, "R6 NAK left released", m_ack, 0);
    do_stop("R6");

    // R12: flag set by engine in the same cycle a write clears it
    wr(2'd0, 8'hE0); expect_status(8'h08, "R2 start");
    send({SLV, 1'b0}, 8'h18, "R4 address");
    auto_tick = 1'b0;
    wr(2'd1, 8'h5A); wr(2'd0, 8'h44);
    repeat (2) @(negedge clk);
    for (int t = 0; t < 35; t++) begin
      @(negedge clk); man_tick = 1'b1;
      @(negedge clk); man_tick = 1'b0;
    end
    rd(2'd0, v); chk(!v[3], "R12 flag clear before last tick", v, 0);
    @(negedge clk); man_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h44;
    @(negedge clk); man_tick = 1'b0; wr_en = 1'b0;
    rd(2'd0, v); chk(v[3], "R12 engine set wins", v, 8'h08);
    rd(2'd2, v); chk(v == 8'h28, "R12 status", v, 8'h28);
    chk(last_rx == 8'h5A, "R12 byte sent", last_rx, 8'h5A);
    auto_tick = 1'b1;
    do_stop("R12");

    // R11: baud load and soft reset mid-byte
    wr(2'd2, 8'h1F);
    chk(baud_cfg == 8'h1F, "R11 baud load", baud_cfg, 8'h1F);
    wr(2'd0, 8'hE0); expect_status(8'h08, "R2 start");
    wr(2'd1, {SLV, 1'b0}); wr(2'd0, 8'hC0);
    repeat (60) @(negedge clk);
    wr(2'd3, 8'h00);
    rd(2'd2, v); chk(v == 8'hF8, "R11 status", v, 8'hF8);
    rd(2'd0, v); chk(v == 8'h00, "R11 control", v, 0);
    chk(baud_cfg == 8'h44, "R11 baud restored", baud_cfg, 8'h44);
    chk(!scl_lo && !sda_lo, "R11 lines released", {scl_lo, sda_lo}, 0);
    wr(2'd0, 8'hE0); expect_status(8'h08, "R11 start after reset");
    send({SLV, 1'b0}, 8'h18, "R11 address after reset");
    do_stop("R11");

    summary;
    $finish;
  end
endmodule